// File: doc/BRIEF.md
# Bit-Clock to Frame-Clock Ratio Monitor

This block watches a bit clock and a frame clock that arrive from an external clock master. Both are sampled in a faster system clock domain. The block counts bit-clock rising edges in every frame-clock period and reports that count. It then judges whether the count is one of the ratios allowed for the selected speed mode. A consumer uses the flags to decide when the serial audio link can be trusted. `valid_o` means a permitted ratio has held steady. `mismatch_o` means the link is misconfigured or unstable. `timeout_o` means the frame clock has stopped.

Both clock inputs pass through a two-flop synchronizer, and rising edges are detected after it. The first frame-clock rising edge after reset, or after a timeout, only starts a count. Every later frame-clock rising edge closes one measurement and starts the next. All outputs are plain status levels, so there is no valid/ready stream and no back-pressure. The measured ratio is held on `ratio_o` until the next frame edge replaces it.

Top module: `ratio_guard`

## Requirements
- R1: At each frame-clock rising edge, `ratio_o` takes the number of bit-clock rising edges seen since the previous frame-clock rising edge. The first frame-clock rising edge after reset or after a timeout only starts counting and produces no measurement.
- R2: A bit-clock rising edge that falls in the same system cycle as a frame-clock rising edge counts toward the new period, not the one being closed.
- R3: The per-period count saturates at 255, so a longer period reports `ratio_o` = 255 and flags a mismatch.
- R4: With `speed_i` = 2'b00 (single speed), the ratios 32, 48, 64 and 128 are legal and every other count is illegal.
- R5: With `speed_i` = 2'b01 (double speed) or 2'b10 (quad speed), only 32, 48 and 64 are legal, so 128 is illegal.
- R6: `valid_o` rises only when a legal measurement equals the measurement just before it. It stays high while further equal legal measurements follow.
- R7: `mismatch_o` is set by any illegal measurement, and by a legal measurement that differs from the previous one. A legal measurement that repeats the previous one clears it. `valid_o` and `mismatch_o` are never high together. The first legal measurement after reset or timeout leaves both low.
- R8: With `speed_i` = 2'b11 (reserved), `mismatch_o` is high and `valid_o` is low at once, whatever has been measured.
- R9: If no frame-clock rising edge arrives for `TIMEOUT_CYC` system cycles, `timeout_o` goes high and `valid_o` goes low. The next frame-clock rising edge clears `timeout_o` and only re-arms counting (see R1).
- R10: After reset, `ratio_o` is 0 and `valid_o`, `mismatch_o` and `timeout_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the bit clock by at least 4x |
| rst_ni | input | 1 | Active-low synchronous reset |
| bit_clk_i | input | 1 | Bit clock from the external master, asynchronous |
| frame_clk_i | input | 1 | Frame clock from the external master, asynchronous |
| speed_i | input | 2 | Speed mode: 00 single, 01 double, 10 quad, 11 reserved |
| ratio_o | output | 8 | Last measured bit-clock edges per frame period |
| valid_o | output | 1 | Ratio legal and repeated over consecutive frames |
| mismatch_o | output | 1 | Ratio illegal, changing, or mode reserved |
| timeout_o | output | 1 | No frame-clock rising edge for TIMEOUT_CYC cycles |

## Verification
Two events can land in the same system cycle: a bit-clock rising edge and a frame-clock rising edge, which both close one count and open the next. The bench provokes this by running some frames with the frame edge aligned to a bit-clock rising edge and others with it aligned to a falling edge. It expects the same ratio either way, because the coincident bit edge belongs to the new period. A second collision is a frame edge arriving while the timeout is already flagged. The bench lets the link fall idle, then restarts it. It checks that the first edge clears the timeout without producing a measurement, and that only the following edge yields a ratio.

// File: rtl/ratio_guard_pkg.sv
package ratio_guard_pkg;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_RSVD   = 2'b11
  } speed_e;

  // Legal bit-clock edges per frame for a given speed code.
  function automatic logic ratio_ok(input logic [1:0] sp, input int unsigned r);
    logic common;
    common = (r == 32) || (r == 48) || (r == 64);
    case (speed_e'(sp))
      SPD_SINGLE: ratio_ok = common || (r == 128);
      SPD_DOUBLE: ratio_ok = common;
      SPD_QUAD:   ratio_ok = common;
      default:    ratio_ok = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rg_edge_sync.sv
module rg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  // STAGES synchronizer flops plus one history flop for edge detection.
  logic [STAGES:0] shift_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) shift_q <= '0;
    else         shift_q <= {shift_q[STAGES-1:0], async_i};
  end

  assign rise_o = shift_q[STAGES-1] & ~shift_q[STAGES];
endmodule

// File: rtl/rg_period_counter.sv
module rg_period_counter #(
  parameter int RATIO_W     = 8,
  parameter int TIMEOUT_CYC = 2048
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_rise_i,
  input  logic               frame_rise_i,
  output logic               stb_o,
  output logic [RATIO_W-1:0] meas_o,
  output logic               timeout_o
);
  localparam logic [RATIO_W-1:0] CNT_MAX = {RATIO_W{1'b1}};
  localparam int WD_W = $clog2(TIMEOUT_CYC);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(TIMEOUT_CYC - 1);

  logic [RATIO_W-1:0] cnt_q;
  logic [WD_W-1:0]    wd_q;
  logic               armed_q;
  logic               timeout_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      wd_q      <= '0;
      armed_q   <= 1'b0;
      timeout_q <= 1'b0;
      stb_o     <= 1'b0;
      meas_o    <= '0;
    end else begin
      stb_o <= 1'b0;
      if (frame_rise_i) begin
        // A coincident bit edge belongs to the period that opens now.
        cnt_q     <= bit_rise_i ? RATIO_W'(1) : '0;
        wd_q      <= '0;
        timeout_q <= 1'b0;
        armed_q   <= 1'b1;
        if (armed_q) begin
          stb_o  <= 1'b1;
          meas_o <= cnt_q;
        end
      end else begin
        if (bit_rise_i && (cnt_q != CNT_MAX)) cnt_q <= cnt_q + 1'b1;
        if (wd_q == WD_LAST) begin
          timeout_q <= 1'b1;
          armed_q   <= 1'b0;
        end else begin
          wd_q <= wd_q + 1'b1;
        end
      end
    end
  end

  assign timeout_o = timeout_q;

  // R3: a saturated count holds until the period closes
  p_sat_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX) && !frame_rise_i |=> (cnt_q == CNT_MAX));

  // R9: a frame edge always ends a timeout
  p_timeout_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_q && frame_rise_i |=> !timeout_q);
endmodule

// File: rtl/rg_ratio_judge.sv
module rg_ratio_judge
  import ratio_guard_pkg::*;
#(
  parameter int RATIO_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         speed_i,
  input  logic               stb_i,
  input  logic [RATIO_W-1:0] meas_i,
  input  logic               stale_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               valid_o,
  output logic               mismatch_o
);
  logic [RATIO_W-1:0] prev_q;
  logic               have_prev_q;
  logic               legal;

  assign legal = ratio_ok(speed_i, 32'(meas_i));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
      ratio_o     <= '0;
      valid_o     <= 1'b0;
      mismatch_o  <= 1'b0;
    end else if (stb_i) begin
      ratio_o     <= meas_i;
      prev_q      <= meas_i;
      have_prev_q <= 1'b1;
      if (!legal) begin
        mismatch_o <= 1'b1;
        valid_o    <= 1'b0;
      end else if (have_prev_q && (prev_q == meas_i)) begin
        mismatch_o <= 1'b0;
        valid_o    <= 1'b1;
      end else begin
        mismatch_o <= have_prev_q;
        valid_o    <= 1'b0;
      end
    end else if (stale_i) begin
      valid_o     <= 1'b0;
      have_prev_q <= 1'b0;
    end
  end

  // R4 / R5: an illegal measurement raises mismatch and drops valid
  p_illegal_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i && !legal |=> mismatch_o && !valid_o);

  // R6: valid only rises on a repeated measurement
  p_valid_repeat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(stb_i) && $past(have_prev_q) && ($past(meas_i) == $past(prev_q)));
endmodule

// File: rtl/ratio_guard.sv
module ratio_guard
  import ratio_guard_pkg::*;
#(
  parameter int RATIO_W     = 8,
  parameter int TIMEOUT_CYC = 2048,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_clk_i,
  input  logic               frame_clk_i,
  input  logic [1:0]         speed_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               valid_o,
  output logic               mismatch_o,
  output logic               timeout_o
);
  localparam int N_CLK = 2;  // index 0: bit clock, 1: frame clock

  logic [N_CLK-1:0]   raw_clk;
  logic [N_CLK-1:0]   rise;
  logic               stb;
  logic [RATIO_W-1:0] meas;
  logic               stale;
  logic               valid_q;
  logic               mismatch_q;
  logic               rsvd;

  assign raw_clk = {frame_clk_i, bit_clk_i};

  for (genvar g = 0; g < N_CLK; g++) begin : g_sync
    rg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(raw_clk[g]),
      .rise_o (rise[g])
    );
  end

  rg_period_counter #(.RATIO_W(RATIO_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_count (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_rise_i  (rise[0]),
    .frame_rise_i(rise[1]),
    .stb_o       (stb),
    .meas_o      (meas),
    .timeout_o   (stale)
  );

  rg_ratio_judge #(.RATIO_W(RATIO_W)) u_judge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .speed_i   (speed_i),
    .stb_i     (stb),
    .meas_i    (meas),
    .stale_i   (stale),
    .ratio_o   (ratio_o),
    .valid_o   (valid_q),
    .mismatch_o(mismatch_q)
  );

  assign rsvd       = (speed_e'(speed_i) == SPD_RSVD);
  assign valid_o    = valid_q & ~rsvd;
  assign mismatch_o = mismatch_q | rsvd;
  assign timeout_o  = stale;

  // R7: the two verdict flags exclude each other
  p_flags_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && mismatch_o));
endmodule

// File: tb/sim_ratio_guard.sv
module sim_ratio_guard;
  localparam int CLK_PERIOD = 10;
  localparam int TO_CYC     = 2048;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bclk = 1'b0;
  logic       fclk = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] ratio;
  logic       valid, mism, tout;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int  m_cnt = 0;
  bit  m_armed = 0;
  bit  m_hp = 0;
  int  m_prev = 0;
  int  m_ratio = 0;
  bit  m_valid = 0;
  bit  m_mis = 0;
  bit  m_to = 0;
  logic [1:0] next_mode = 2'b00;
  string chk_tag = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  ratio_guard #(.TIMEOUT_CYC(TO_CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bit_clk_i(bclk), .frame_clk_i(fclk),
    .speed_i(mode), .ratio_o(ratio), .valid_o(valid), .mismatch_o(mism),
    .timeout_o(tout)
  );

  function automatic bit legal_m(input int md, input int r);
    if (md == 0) return (r == 32 || r == 48 || r == 64 || r == 128);
    if (md == 1 || md == 2) return (r == 32 || r == 48 || r == 64);
    return 0;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    bit rsv;
    rsv = (mode == 2'b11);
    chk(tag, "ratio_o", int'(ratio), m_ratio);
    chk(tag, "valid_o", int'(valid), int'(m_valid && !rsv));
    chk(tag, "mismatch_o", int'(mism), int'(m_mis || rsv));
    chk(tag, "timeout_o", int'(tout), int'(m_to));
  endtask

  task automatic ev_frame();
    int m;
    if (m_armed) begin
      m = (m_cnt > 255) ? 255 : m_cnt;   // R3 saturation
      m_ratio = m;
      if (!legal_m(int'(mode), m)) begin m_mis = 1; m_valid = 0; end
      else if (m_hp && m_prev == m) begin m_mis = 0; m_valid = 1; end
      else if (m_hp) begin m_mis = 1; m_valid = 0; end
      else begin m_mis = 0; m_valid = 0; end
      m_prev = m;
      m_hp = 1;
    end
    m_armed = 1;
    m_to = 0;
    m_cnt = 0;
  endtask

  task automatic pause_check();
    repeat (8) @(negedge clk);
    check_all(chk_tag);
    mode = next_mode;
  endtask

  // one frame of n bit periods, each phase h system cycles
  task automatic drive_frame(input int n, input bit al, input int h, input bit do_chk);
    for (int b = 0; b < n; b++) begin
      bclk = 1'b0;
      if (!al && b == 0) begin fclk = 1'b1; ev_frame(); end
      if (b == n/2) fclk = 1'b0;
      if (!al && b == 0 && do_chk) pause_check();
      repeat (h) @(negedge clk);
      if (al && b == 0) begin fclk = 1'b1; ev_frame(); end
      bclk = 1'b1;
      m_cnt++;
      if (al && b == 0 && do_chk) pause_check();
      repeat (h) @(negedge clk);
    end
  endtask

  task automatic seq(input int n, input int k, input bit al, input int h,
                     input logic [1:0] md, input string tag);
    next_mode = md;
    for (int f = 0; f < k; f++) drive_frame(n, al, h, f == 0);
    chk_tag = tag;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4265));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R10");

    seq(32, 3, 0, 2, 2'b00, "R1_R6 ratio 32 repeated");
    seq(48, 3, 1, 2, 2'b01, "R2 coincident edges, 48");
    seq(48, 3, 0, 3, 2'b01, "R2 non-coincident, 48");
    seq(128, 2, 0, 2, 2'b00, "R4 single 128");
    seq(128, 2, 1, 2, 2'b10, "R5 quad 128");
    seq(128, 2, 0, 2, 2'b01, "R5 double 128");
    seq(64, 1, 0, 2, 2'b00, "R7 single 64 once");
    seq(32, 1, 0, 2, 2'b00, "R7 changed to 32");
    seq(32, 1, 0, 2, 2'b00, "R7 repeat 32 clears");
    seq(40, 2, 0, 2, 2'b00, "R4 illegal 40");
    seq(300, 2, 0, 2, 2'b00, "R3 saturated count");
    seq(64, 3, 0, 2, 2'b01, "R6 double 64");
    drive_frame(64, 0, 2, 1);

    // R8: reserved code overrides a valid verdict at once
    chk_tag = "R6 before reserved";
    next_mode = 2'b11;
    drive_frame(64, 0, 2, 1);
    repeat (2) @(negedge clk);
    check_all("R8 reserved mode");
    chk("R8", "mismatch_o", int'(mism), 1);
    mode = 2'b01;
    next_mode = 2'b01;
    drive_frame(64, 0, 2, 0);

    // R9: idle link times out, first edge afterwards only re-arms
    bclk = 1'b0;
    fclk = 1'b0;
    repeat (TO_CYC + 60) @(negedge clk);
    m_to = 1; m_valid = 0; m_hp = 0; m_armed = 0; m_cnt = 0;
    check_all("R9 timeout raised");
    chk("R9", "valid_o", int'(valid), 0);
    chk_tag = "R9 re-arm after timeout";
    seq(48, 2, 0, 2, 2'b00, "R9 R1 first ratio after timeout");
    seq(48, 2, 0, 2, 2'b00, "R6 after timeout");

    for (int i = 0; i < 30; i++) begin
      int pick;
      int n;
      pick = int'($urandom_range(0, 6));
      case (pick)
        0: n = 32; 1: n = 48; 2: n = 64; 3: n = 128; 4: n = 24; 5: n = 96;
        default: n = 40;
      endcase
      seq(n, int'($urandom_range(1, 3)), 1'($urandom_range(0, 1)),
          int'($urandom_range(2, 3)), 2'($urandom_range(0, 2)),
          "R1_R4_R5_R6_R7 random");
    end
    drive_frame(32, 0, 2, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule